// File: doc/BRIEF.md
# Path trace message buffer with compare

This block keeps the trace message that arrives one byte per frame. A received message is copied into an accepted buffer only after the same content has arrived several times in a row. The block also holds an expected message written by the host. It compares the two buffers over the configured length and raises a mismatch output when they differ.

The host has two targets, chosen by `host_win`: a single control register and a 64-location byte window. A select bit in the control register maps the window to either the accepted buffer or the expected buffer. A status bit reports that a complete expected message has been written. The framing rule (a start-marker byte or a CR/LF terminator), the message length and the repetition count are all set in the control register. The incoming byte stream is assumed to be already extracted from the frame.

Top module: `trace_msg_buf`

## Requirements
- R1: After synchronous reset, the control register reads 0x00, `mismatch` is 0, and every byte of both buffers reads 0x00 through the window.
- R2: The control register (`host_win`=0) has these fields: [1:0] length code, [2] framing mode, [3] repetition threshold, [4] window select. They are written and read back. Bit [5] is the expected-ready flag. Writing 1 to bit 5 clears the flag, writing 0 leaves it unchanged, and a host write never sets it. Bits [7:6] read 0.
- R3: With `host_win`=1, `host_addr` picks byte 0..63 of the window. With select 0 the window reads the accepted buffer, and writes to it are ignored. With select 1 the window reads the expected buffer, and writes update it.
- R4: The length code maps 00 to 1 byte, 01 to 16 bytes, and 10 or 11 to 64 bytes (L). A window write with select 1 at address L-1 sets the expected-ready flag in the next cycle. Writes at other addresses do not set it.
- R5: A message is copied into the accepted buffer when it completes its 3rd consecutive identical reception (threshold 0) or its 5th (threshold 1). The copy is readable two clock edges after its last byte is sampled. With fewer receptions, the accepted buffer is unchanged.
- R6: A completed message that differs from the previous complete message restarts the repetition run at one.
- R7: In framing mode 0, a received byte with bit 7 set is stored at index 0. If it arrives while the write index is not 0, the partial message is dropped and the new message counts as the first of a run.
- R8: In framing mode 1, a message also completes by count at index L-1. A byte 0x0A that directly follows 0x0D at any index other than L-1 realigns the stream: that byte is not stored, the next byte goes to index 0, and the run count is cleared.
- R9: While a message has been accepted and the expected-ready flag is set, `mismatch` follows (one cycle later) whether any of bytes 0..L-1 differ between the two buffers. Bytes at index L and above do not count. While either condition is false, `mismatch` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received trace byte is present this cycle |
| rx_byte | input | 8 | Received trace byte |
| host_wr | input | 1 | Host write strobe |
| host_win | input | 1 | 1 selects the byte window, 0 the control register |
| host_addr | input | 6 | Window byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| mismatch | output | 1 | Accepted and expected messages differ |

## Verification
The hardest states to reach from the ports are the ones where the run counter sits exactly one reception short of the threshold, or has just been broken by a realignment. The bench reaches them by sending exact numbers of whole messages and reading the window after each group. It places a truncated message in front of the runs: a partial message beginning with a start marker, or a CR/LF pair at the wrong index. It also breaks a run with one differing message. The compare path is driven by editing single expected bytes, inside and outside the configured length, while the ready flag is set and after it has been cleared.

// File: rtl/trace_msg_pkg.sv
package trace_msg_pkg;

    localparam int MSG_DEPTH = 64;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = $clog2(MSG_DEPTH);
    localparam int SHORT_LEN = 16;
    localparam int RUN_LO    = 3;
    localparam int RUN_HI    = 5;
    localparam int RUN_W     = $clog2(RUN_HI + 1);

    typedef logic [BYTE_W-1:0]                 byte_t;
    typedef logic [IDX_W-1:0]                  idx_t;
    typedef logic [IDX_W:0]                    len_t;
    typedef logic [RUN_W-1:0]                  run_t;
    typedef logic [MSG_DEPTH-1:0][BYTE_W-1:0]  msg_t;

    // Control fields, most significant first so the packed value
    // lines up with register bits [4:0].
    typedef struct packed {
        logic       sel;
        logic       thr;
        logic       align;
        logic [1:0] len;
    } cfg_t;

    localparam byte_t ASCII_CR = 8'h0D;
    localparam byte_t ASCII_LF = 8'h0A;

    function automatic len_t len_bytes(input logic [1:0] code);
        case (code)
            2'b00:   return len_t'(1);
            2'b01:   return len_t'(SHORT_LEN);
            default: return len_t'(MSG_DEPTH);
        endcase
    endfunction

    function automatic idx_t last_index(input logic [1:0] code);
        return idx_t'(len_bytes(code) - len_t'(1));
    endfunction

    function automatic run_t run_target(input logic thr);
        return thr ? run_t'(RUN_HI) : run_t'(RUN_LO);
    endfunction

endpackage

// File: rtl/trace_capture.sv
module trace_capture
    import trace_msg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rx_valid,
    input  byte_t rx_byte,
    input  cfg_t  cfg,
    output msg_t  cap,
    output logic  accept
);

    idx_t idx;
    run_t run;
    logic same_q;
    logic prev_cr;

    idx_t last;
    idx_t pos;
    run_t target;
    run_t run_nx;
    logic lf_end;
    logic resync;
    logic restart;
    logic eq;
    logic same_nx;
    logic done;

    always_comb begin
        last    = last_index(cfg.len);
        target  = run_target(cfg.thr);
        lf_end  = cfg.align && prev_cr && (rx_byte == ASCII_LF);
        resync  = lf_end && (idx != last);
        restart = !cfg.align && rx_byte[BYTE_W-1] && (idx != '0);
        pos     = restart ? '0 : idx;
        // Compare against the previous message at the same position.
        eq      = (rx_byte == cap[pos]);
        same_nx = (pos == '0) ? eq : (same_q && eq);
        done    = !resync && (pos >= last);
        if (same_nx && (run != '0))
            run_nx = (run >= target) ? target : run + run_t'(1);
        else
            run_nx = run_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            run     <= '0;
            same_q  <= 1'b0;
            prev_cr <= 1'b0;
            accept  <= 1'b0;
            cap     <= '0;
        end else begin
            accept <= 1'b0;
            if (rx_valid) begin
                if (resync) begin
                    idx     <= '0;
                    run     <= '0;
                    prev_cr <= 1'b0;
                end else begin
                    cap[pos] <= rx_byte;
                    prev_cr  <= (rx_byte == ASCII_CR);
                    same_q   <= same_nx;
                    if (done) begin
                        idx    <= '0;
                        run    <= run_nx;
                        accept <= (run_nx == target);
                    end else begin
                        idx <= pos + idx_t'(1);
                        if (restart)
                            run <= '0;
                    end
                end
            end
        end
    end

    // R5: the run counter never passes the larger threshold
    p_run_bound_r5: assert property (@(posedge clk) disable iff (rst)
        run <= run_t'(RUN_HI));

    // R8: a realignment leaves the next byte aimed at index 0
    p_resync_idx_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && resync) |=> (idx == '0) && (run == '0));

endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
    import trace_msg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  host_wr,
    input  logic  host_win,
    input  idx_t  host_addr,
    input  byte_t host_wdata,
    output cfg_t  cfg,
    output logic  ready,
    output logic  exp_wr,
    output byte_t ctrl_rdata
);

    logic set_ready;

    always_comb begin
        exp_wr     = host_wr && host_win && cfg.sel;
        set_ready  = exp_wr && (host_addr == last_index(cfg.len));
        ctrl_rdata = {2'b00, ready, cfg};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            ready <= 1'b0;
        end else begin
            if (host_wr && !host_win) begin
                cfg <= cfg_t'(host_wdata[4:0]);
                if (host_wdata[5])
                    ready <= 1'b0;
            end
            if (set_ready)
                ready <= 1'b1;
        end
    end

    // R2: writing 1 to the flag bit clears it
    p_w1c_r2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_win && host_wdata[5]) |=> !ready);

    // R2: a register write without the clear bit never raises the flag
    p_no_host_set_r2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_win && !host_wdata[5] && !ready) |=> !ready);

endmodule

// File: rtl/trace_store.sv
module trace_store
    import trace_msg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  msg_t  cap,
    input  logic  accept,
    input  logic  exp_wr,
    input  idx_t  addr,
    input  byte_t wdata,
    input  cfg_t  cfg,
    input  logic  ready,
    output byte_t win_rdata,
    output logic  mismatch
);

    msg_t acc;
    msg_t expv;
    logic acc_valid;
    logic [MSG_DEPTH-1:0] hit;
    len_t n;

    assign n = len_bytes(cfg.len);

    for (genvar i = 0; i < MSG_DEPTH; i++) begin : g_cmp
        assign hit[i] = (len_t'(i) < n) && (acc[i] != expv[i]);
    end

    assign win_rdata = cfg.sel ? expv[addr] : acc[addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= '0;
            expv      <= '0;
            acc_valid <= 1'b0;
            mismatch  <= 1'b0;
        end else begin
            if (accept) begin
                acc       <= cap;
                acc_valid <= 1'b1;
            end
            if (exp_wr)
                expv[addr] <= wdata;
            if (acc_valid && ready)
                mismatch <= |hit;
        end
    end

    // R5: an accept copies the captured message as it stood
    p_acc_copy_r5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (acc == $past(cap)));

    // R3: the accepted buffer changes only through acceptance
    p_acc_ro_r3: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(acc));

    // R9: without an accepted message and a ready flag the flag holds
    p_mis_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && ready) |=> $stable(mismatch));

endmodule

// File: rtl/trace_msg_buf.sv
module trace_msg_buf
    import trace_msg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       host_wr,
    input  logic       host_win,
    input  logic [5:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       mismatch
);

    cfg_t  cfg;
    logic  ready;
    logic  exp_wr;
    byte_t ctrl_rdata;
    byte_t win_rdata;
    msg_t  cap;
    logic  accept;

    trace_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_win   (host_win),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .cfg        (cfg),
        .ready      (ready),
        .exp_wr     (exp_wr),
        .ctrl_rdata (ctrl_rdata)
    );

    trace_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .cfg      (cfg),
        .cap      (cap),
        .accept   (accept)
    );

    trace_store u_store (
        .clk       (clk),
        .rst       (rst),
        .cap       (cap),
        .accept    (accept),
        .exp_wr    (exp_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .cfg       (cfg),
        .ready     (ready),
        .win_rdata (win_rdata),
        .mismatch  (mismatch)
    );

    assign host_rdata = host_win ? win_rdata : ctrl_rdata;

    // R4: writing the last expected byte of the length raises the flag
    p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_win && cfg.sel && (host_addr == last_index(cfg.len)))
        |=> (host_rdata[5] || host_win));

endmodule

// File: tb/trace_msg_buf_bench.sv
module trace_msg_buf_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       host_wr = 1'b0;
    logic       host_win = 1'b0;
    logic [5:0] host_addr = 6'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       mismatch;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    trace_msg_buf u_trace_msg_buf (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .host_wr    (host_wr),
        .host_win   (host_win),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mismatch   (mismatch)
    );

    // Fields: [13:12] length code, [11] framing, [10] threshold,
    // [9:6] repetitions, [5:1] seed, [0] accepted expected
    localparam logic [13:0] VEC [0:6] = '{
        {2'b01, 1'b0, 1'b0, 4'd2, 5'd3,  1'b0},
        {2'b01, 1'b0, 1'b0, 4'd3, 5'd4,  1'b1},
        {2'b01, 1'b0, 1'b1, 4'd4, 5'd5,  1'b0},
        {2'b01, 1'b0, 1'b1, 4'd5, 5'd6,  1'b1},
        {2'b10, 1'b1, 1'b0, 4'd3, 5'd7,  1'b1},
        {2'b00, 1'b0, 1'b0, 4'd3, 5'd9,  1'b1},
        {2'b11, 1'b1, 1'b1, 4'd4, 5'd11, 1'b0}
    };

    function automatic int nbytes(input logic [1:0] code);
        return (code == 2'b00) ? 1 : (code == 2'b01) ? 16 : 64;
    endfunction

    function automatic logic [7:0] mb(input logic align, input int n,
                                      input int seed, input int i);
        if (!align)
            return (i == 0) ? (8'h80 | 8'(seed)) : 8'(8'h20 + ((i + seed) % 64));
        if (i == n - 1) return 8'h0A;
        if (i == n - 2) return 8'h0D;
        return 8'(8'h41 + ((i + seed) % 26));
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_valid = 1'b0; host_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic win, input int a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_win = win; host_addr = 6'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic win, input int a, output logic [7:0] d);
        @(negedge clk);
        host_win = win; host_addr = 6'(a);
        #1 d = host_rdata;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
    endtask

    task automatic idle();
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_msg(input logic align, input int n, input int seed, input int cnt);
        for (int k = 0; k < cnt; k++)
            for (int i = 0; i < n; i++)
                send_byte(mb(align, n, seed, i));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;

        // R1: reset state
        do_reset();
        rd(1'b0, 0, d);  check("R1 ctrl", d, 8'h00);
        check("R1 mismatch", {7'd0, mismatch}, 8'h00);
        rd(1'b1, 0, d);  check("R1 acc[0]", d, 8'h00);
        rd(1'b1, 63, d); check("R1 acc[63]", d, 8'h00);
        wr(1'b0, 0, 8'h10);
        rd(1'b1, 63, d); check("R1 exp[63]", d, 8'h00);

        // R2: field readback, flag not settable, upper bits zero
        wr(1'b0, 0, 8'hFF);
        rd(1'b0, 0, d);  check("R2 readback", d, 8'h1F);
        wr(1'b0, 0, 8'h00);

        // Table: thresholds, lengths and framing modes (R5, R7, R8)
        for (int v = 0; v < 7; v++) begin
            logic [13:0] e;
            int n;
            e = VEC[v];
            n = nbytes(e[13:12]);
            do_reset();
            wr(1'b0, 0, {4'h0, e[10], e[11], e[13:12]});
            send_msg(e[11], n, int'(e[5:1]), int'(e[9:6]));
            idle();
            rd(1'b1, n - 1, d);
            check($sformatf("R5 row%0d last", v), d,
                  e[0] ? mb(e[11], n, int'(e[5:1]), n - 1) : 8'h00);
            rd(1'b1, 0, d);
            check($sformatf("R5 row%0d first", v), d,
                  e[0] ? mb(e[11], n, int'(e[5:1]), 0) : 8'h00);
        end

        // R6: a differing message breaks the run
        do_reset();
        wr(1'b0, 0, 8'h01);
        send_msg(1'b0, 16, 2, 2);
        send_msg(1'b0, 16, 8, 1);
        send_msg(1'b0, 16, 2, 2);
        idle();
        rd(1'b1, 1, d); check("R6 broken run", d, 8'h00);
        send_msg(1'b0, 16, 2, 1);
        idle();
        rd(1'b1, 1, d); check("R6 new run", d, mb(1'b0, 16, 2, 1));

        // R4/R9/R3/R2: expected load, compare, window access, flag clear
        wr(1'b0, 0, 8'h11);
        for (int i = 0; i < 15; i++) wr(1'b1, i, mb(1'b0, 16, 2, i));
        rd(1'b0, 0, d); check("R4 not last", d, 8'h11);
        wr(1'b1, 15, mb(1'b0, 16, 2, 15));
        rd(1'b0, 0, d); check("R4 last sets", d, 8'h31);
        wr(1'b1, 20, 8'hFF);
        repeat (2) @(negedge clk);
        check("R9 match beyond len", {7'd0, mismatch}, 8'h00);
        rd(1'b1, 20, d); check("R3 exp read", d, 8'hFF);
        wr(1'b1, 3, mb(1'b0, 16, 2, 3) ^ 8'h01);
        repeat (2) @(negedge clk);
        check("R9 differ", {7'd0, mismatch}, 8'h01);
        wr(1'b1, 3, mb(1'b0, 16, 2, 3));
        repeat (2) @(negedge clk);
        check("R9 match again", {7'd0, mismatch}, 8'h00);
        wr(1'b0, 0, 8'h01);
        rd(1'b0, 0, d); check("R2 write 0 keeps flag", d, 8'h21);
        wr(1'b1, 1, 8'h77);
        rd(1'b1, 1, d); check("R3 acc write ignored", d, mb(1'b0, 16, 2, 1));
        wr(1'b0, 0, 8'h21);
        rd(1'b0, 0, d); check("R2 w1c", d, 8'h01);
        wr(1'b0, 0, 8'h11);
        wr(1'b1, 3, 8'h00);
        repeat (2) @(negedge clk);
        check("R9 hold without flag", {7'd0, mismatch}, 8'h00);

        // R7: start marker in mid-message realigns
        do_reset();
        wr(1'b0, 0, 8'h01);
        for (int i = 0; i < 5; i++) send_byte(mb(1'b0, 16, 12, i));
        send_msg(1'b0, 16, 12, 2);
        idle();
        rd(1'b1, 1, d); check("R7 partial dropped", d, 8'h00);
        send_msg(1'b0, 16, 12, 1);
        idle();
        rd(1'b1, 1, d); check("R7 accepted", d, mb(1'b0, 16, 12, 1));

        // R8: CR/LF at the wrong index realigns
        do_reset();
        wr(1'b0, 0, 8'h06);
        for (int i = 0; i < 10; i++) send_byte(8'h50);
        send_byte(8'h0D);
        send_byte(8'h0A);
        send_msg(1'b1, 64, 13, 2);
        idle();
        rd(1'b1, 63, d); check("R8 not yet", d, 8'h00);
        send_msg(1'b1, 64, 13, 1);
        idle();
        rd(1'b1, 63, d); check("R8 accepted last", d, 8'h0A);
        rd(1'b1, 0, d);  check("R8 accepted first", d, mb(1'b1, 64, 13, 0));

        // R4: flag position follows the length code
        do_reset();
        wr(1'b0, 0, 8'h10);
        wr(1'b1, 0, 8'h5A);
        rd(1'b0, 0, d); check("R4 len1", d, 8'h30);
        do_reset();
        wr(1'b0, 0, 8'h12);
        wr(1'b1, 15, 8'h5A);
        rd(1'b0, 0, d); check("R4 len64 mid", d, 8'h12);
        wr(1'b1, 63, 8'h5A);
        rd(1'b0, 0, d); check("R4 len64 last", d, 8'h32);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule